// File: doc/BRIEF.md
# Masked Interrupt Control Register

This block collects event pulses from five sources: timer A underflow, timer B underflow, alarm match, serial port and flag input. Each pulse sets a sticky flag bit. A five-bit enable mask decides which flags may raise the single active-low interrupt line. One register address serves both directions. A write updates the mask, and bit 7 of the written byte chooses whether the 1 bits set mask bits or clear them. The status byte shows the flags and a summary bit. A read strobe clears all flags on the next clock edge.

The status byte is driven continuously from the block's state, so the surrounding bus logic can sample it in the cycle it asserts the read strobe. The read strobe and the write strobe are plain single-cycle control pins with no handshake, because the block always accepts an access in the cycle it is presented. The event sources are outside the block.

Top module: `irq_ctl_reg`

## Requirements
- R1: The status byte has the summary at bit 7, zeros at bits 6:5, and flags at bits 4:0. The flag order is timer A at bit 0, timer B at bit 1, alarm at bit 2, serial at bit 3 and flag input at bit 4. Event input bit i drives flag bit i.
- R2: A 1 on event input bit i sets flag i at the next clock edge, whether or not mask bit i is set.
- R3: A flag stays set until a read strobe clears it.
- R4: While the read strobe is high, the status byte shows the values in place before the clear. All flags are 0 after that clock edge.
- R5: An event that arrives in the same cycle as a read strobe leaves its flag set after the edge.
- R6: A write with bit 7 = 1 sets each mask bit i for which written bit i (i in 4:0) is 1.
- R7: A write with bit 7 = 0 clears each mask bit i for which written bit i is 1.
- R8: A mask bit whose written bit is 0 keeps its value. Written bits 6:5 have no effect on the mask or the status byte.
- R9: The summary bit is 1, and the interrupt output is low, exactly when some flag and its mask bit are both 1.
- R10: Reset clears all flags and mask bits. The status byte then reads 0x00 and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 5 | Event pulses, one per source |
| wr_en | input | 1 | Write strobe for the mask |
| wr_data | input | 8 | Write byte: bit 7 is set/clear, bits 4:0 select mask bits |
| rd_en | input | 1 | Read strobe; clears flags at the edge |
| rd_data | output | 8 | Status byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets an event in the same cycle as a read. A design that lets the clear win would lose that event. It writes mask bytes with zero bits and with bits 6:5 set. A design that writes the whole field, or decodes the unused bits, would change the interrupt line. It raises flags on masked sources and then unmasks them later. A design that gates latching with the mask would never assert the interrupt. Random mixes of reads, writes and events run against a bench model of flags and mask. That comparison catches a polarity swap in the set/clear bit or a summary that ignores the mask.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NSRC    = 5;
  localparam int REG_W   = 8;
  localparam int SEL_POS = 7;
  typedef enum logic [2:0] {
    SRC_TMRA = 3'd0,
    SRC_TMRB = 3'd1,
    SRC_ALRM = 3'd2,
    SRC_SER  = 3'd3,
    SRC_FLAG = 3'd4
  } src_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end

    // R2 / R5: an event always lands, even alongside a clear
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    // R3: no clear means a set flag stays set
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr) |=> flags[i]);
  end

  // R4: a clear with no new events empties the bank
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_sel,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] mask
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask[i] <= 1'b0;
      else if (wr_en && wr_bits[i]) mask[i] <= set_sel;
    end

    // R6
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && set_sel && wr_bits[i]) |=> mask[i]);
    // R7
    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !set_sel && wr_bits[i]) |=> !mask[i]);
    // R8
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !wr_bits[i]) |=> $stable(mask[i]));
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int N     = 5,
  parameter int REG_W = 8
) (
  input  logic [N-1:0]     flags,
  input  logic [N-1:0]     mask,
  output logic [REG_W-1:0] status,
  output logic             pending
);
  localparam int PAD = REG_W - 1 - N;
  always_comb begin
    pending = |(flags & mask);
    status  = {pending, {PAD{1'b0}}, flags};
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  evt,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] mask;
  logic            pending;

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(rd_en), .flags(flags)
  );

  irq_mask_reg #(.N(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .set_sel(wr_data[SEL_POS]),
    .wr_bits(wr_data[NSRC-1:0]), .mask(mask)
  );

  irq_summary #(.N(NSRC), .REG_W(REG_W)) u_sum (
    .flags(flags), .mask(mask), .status(rd_data), .pending(pending)
  );

  assign irq_n = ~pending;

  // R9: a flag with its enable set pulls the line low
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & mask) != '0) |-> !irq_n);
  // R1: the unused bits never read as 1
  p_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-2:NSRC] == '0);
  // R10: the first cycle after reset shows an idle register
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0 && irq_n));
endmodule

// File: tb/irq_ctl_reg_test.sv
module irq_ctl_reg_test;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  logic [4:0] m_flags = '0;
  logic [4:0] m_mask  = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_status(logic [4:0] f, logic [4:0] m);
    return {|(f & m), 2'b00, f};
  endfunction

  task automatic check(string tag);
    logic [7:0] es;
    es = exp_status(m_flags, m_mask);
    n_chk++;
    if (rd_data !== es) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, es);
    end
    n_chk++;
    if (irq_n !== ~es[7]) begin
      n_bad++;
      $display("FAIL %s irq_n actual=%b expected=%b", tag, irq_n, ~es[7]);
    end
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic step(logic [4:0] e, logic w, logic [7:0] wd, logic r, string tag);
    evt = e; wr_en = w; wr_data = wd; rd_en = r;
    @(posedge clk);
    m_flags = (r ? 5'b0 : m_flags) | e;
    if (w)
      for (int i = 0; i < 5; i++) if (wd[i]) m_mask[i] = wd[7];
    @(negedge clk);
    evt = '0; wr_en = 0; wr_data = '0; rd_en = 0;
    #1;
    check(tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release");

    // R2: masked event still latches, no interrupt
    step(5'b00100, 0, 8'h00, 0, "R2 masked event latches");
    // R9: unmask it later, interrupt appears
    step(5'b00000, 1, 8'h84, 0, "R9 unmask raises irq");
    // R3: flag holds over idle cycles
    step(5'b00000, 0, 8'h00, 0, "R3 hold");
    step(5'b00000, 0, 8'h00, 0, "R3 hold");
    // R4: status visible during read, cleared after
    evt = '0; rd_en = 1; #1;
    held = rd_data;
    n_chk++;
    if (held !== 8'h84) begin
      n_bad++;
      $display("FAIL R4 status during read actual=%h expected=%h", held, 8'h84);
    end
    step(5'b00000, 0, 8'h00, 1, "R4 read clears");
    // R5: event coincident with read survives
    step(5'b00001, 0, 8'h00, 0, "R5 setup");
    step(5'b10000, 0, 8'h00, 1, "R5 event during read");
    // R8: bits 6:5 ignored, zero bits hold
    step(5'b00000, 1, 8'he0, 0, "R8 unused bits set");
    step(5'b00000, 1, 8'h60, 0, "R8 unused bits clear");
    step(5'b00000, 1, 8'h80, 0, "R8 empty set");
    // R6: set mask for flag input
    step(5'b00000, 1, 8'h90, 0, "R6 set mask bit4");
    // R7: clear mask bit 4, keep bit 2
    step(5'b00000, 1, 8'h10, 0, "R7 clear mask bit4");
    step(5'b00100, 0, 8'h00, 0, "R7 bit2 still enabled");
    // R1: each source at its own bit position
    for (int i = 0; i < 5; i++) begin
      step(5'b00000, 0, 8'h00, 1, "R1 clear");
      step(5'(1 << i), 0, 8'h00, 0, "R1 bit position");
    end

    // random mix
    void'($urandom(32'h1c0de5));
    for (int k = 0; k < 400; k++) begin
      logic [4:0] e;
      logic [7:0] wd;
      e  = (($urandom % 4) == 0) ? 5'($urandom) : 5'b0;
      wd = 8'($urandom);
      step(e, ($urandom % 5) == 0, wd, ($urandom % 5) == 0, "R9 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule